// File: doc/BRIEF.md
# Single-Vector Interrupt Acceptance Unit

This unit sits next to the fetch stage of a small 8-bit processor. It decides at which instruction boundary a maskable interrupt is taken. The request input is active low and level sensitive. It is looked at only on cycles the core marks as an instruction boundary. A request is taken only when the interrupt-enable flag is set and the one-instruction mask that follows an enable is not active. When a request is taken, the enable flag is cleared. The unit then holds the program counter and replaces the next opcode fetch with a one-byte restart opcode. The decoder executes that opcode as a call to a fixed vector: it pushes the unadvanced program counter and jumps to the vector address.

Enable and disable instructions reach the unit as one-cycle strobes from the decoder. After an enable, the request line is ignored for exactly one boundary. A service routine that ends with enable-then-return therefore always completes its return before a request that is still held low is taken again. The stack, the datapath and any polling of peripherals inside the service routine are outside this unit.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, ieFlag is 0, holdPc is 0, injectValid is 0 and injectOpcode is 8'h00.
- R2: A request is taken on a cycle with instrBoundary=1 and irqN=0 only when all three of these hold: ieFlag is 1, the post-enable mask is clear, and no injection is already pending. In any other case holdPc stays 0 on the following cycle.
- R3: From the cycle after the taken boundary, holdPc is 1 until the first cycle with fetchReady=1. In that cycle injectValid is 1 (injectValid = holdPc AND fetchReady). injectValid is high for exactly one cycle per taken request, and holdPc falls on the next cycle.
- R4: While injectValid is 1, injectOpcode is the restart encoding 2'b11, vector[5:3], 3'b111. For the default vector 16'h0038 this is 8'hFF. At all other times injectOpcode is 8'h00.
- R5: ieFlag is 0 on the cycle after a taken boundary.
- R6: eiExec=1 makes ieFlag 1 on the next cycle. The first boundary strictly after the eiExec cycle cannot take a request. The boundary after that one can.
- R7: diExec=1 makes ieFlag 0 on the next cycle, with no delay slot. If eiExec and diExec coincide, diExec wins.
- R8: The request is a level, not an edge. irqN low on a non-boundary cycle is not remembered. A request still held low after the handler is accepted at the first boundary where R2 allows it.
- R9: If eiExec coincides with a boundary that takes a request, the acceptance stands and ieFlag is 0 on the next cycle.
- R10: Reset drops a pending injection: holdPc and injectValid are 0 after reset, even if a request had just been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| irqN | input | 1 | Interrupt request, active low, level sensitive |
| instrBoundary | input | 1 | High on the cycle where the core decides the next fetch |
| eiExec | input | 1 | One-cycle strobe: an enable instruction executed |
| diExec | input | 1 | One-cycle strobe: a disable instruction executed |
| fetchReady | input | 1 | Fetch stage would read an opcode this cycle |
| injectValid | output | 1 | Substitute opcode presented this cycle; memory read suppressed |
| injectOpcode | output | 8 | Restart opcode while injectValid, else zero |
| holdPc | output | 1 | Program counter must not advance |
| ieFlag | output | 1 | Current interrupt-enable flag |

## Verification
Directed sequences are run first:
- a request while disabled, to separate the flag gate from the request level;
- enable followed by a held request, to show the masked boundary and then the taken one;
- a delayed fetchReady, to show holdPc being held before the single injection cycle;
- enable and disable on the same cycle, and enable coinciding with a taken boundary, to show the priority rules;
- a reset during a pending injection.

A long pseudo-random run then drives all 32 combinations of the five inputs from every reachable state. It compares each cycle against an arithmetic model built from the requirements. This separates mask timing, level re-acceptance and the one-cycle injection pulse.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  // Strobes from the decision logic to the state registers.
  typedef struct packed {
    logic take;      // request accepted at this boundary
    logic setIe;     // enable instruction takes effect
    logic clrIe;     // flag cleared (accept or disable)
    logic dropMask;  // post-enable mask expires
  } ctlStrobes_t;

  // Restart opcode: 11 ttt 111, where ttt selects vector ttt*8.
  function automatic logic [7:0] restartOpcode(input logic [2:0] slot);
    return {2'b11, slot, 3'b111};
  endfunction

endpackage

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        irqN,
  input  logic        instrBoundary,
  input  logic        eiExec,
  input  logic        diExec,
  input  logic        ieFlag,
  input  logic        maskActive,
  input  logic        pending,
  output ctlStrobes_t strobes
);

  logic requestSeen;
  logic gateOpen;

  always_comb begin
    requestSeen = instrBoundary && !irqN;
    gateOpen    = ieFlag && !maskActive && !pending;

    strobes.take     = requestSeen && gateOpen;
    strobes.clrIe    = strobes.take || diExec;
    strobes.setIe    = eiExec && !strobes.clrIe;
    strobes.dropMask = instrBoundary || strobes.clrIe;
  end

  // R2
  take_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |-> ieFlag);

  // R7
  di_blocks_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    diExec |-> !strobes.setIe);

endmodule

// File: rtl/irq_accept_datapath.sv
module irq_accept_datapath
  import irq_accept_pkg::*;
#(
  parameter logic [7:0] RST_OPCODE = 8'hFF
)(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        fetchReady,
  output logic        ieFlag,
  output logic        maskActive,
  output logic        pending,
  output logic        injectValid,
  output logic [7:0]  injectOpcode,
  output logic        holdPc
);

  logic ieQ, maskQ, pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ   <= 1'b0;
      maskQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (strobes.clrIe)      ieQ <= 1'b0;
      else if (strobes.setIe) ieQ <= 1'b1;

      if (strobes.setIe)         maskQ <= 1'b1;
      else if (strobes.dropMask) maskQ <= 1'b0;

      if (strobes.take)                pendQ <= 1'b1;
      else if (pendQ && fetchReady)    pendQ <= 1'b0;
    end
  end

  always_comb begin
    ieFlag       = ieQ;
    maskActive   = maskQ;
    pending      = pendQ;
    holdPc       = pendQ;
    injectValid  = pendQ && fetchReady;
    injectOpcode = injectValid ? RST_OPCODE : 8'h00;
  end

  // R5
  flag_cleared_on_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> !ieQ);

  // R3
  single_inject_chk: assert property (@(posedge clk) disable iff (!rstN)
    injectValid |=> !injectValid && !holdPc);

  // R6
  rise_needs_open_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(ieQ) && !$past(maskQ));

  // R4
  opcode_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    injectValid |-> injectOpcode[7:6] == 2'b11 && injectOpcode[2:0] == 3'b111);

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter logic [15:0] VECTOR_ADDR = 16'h0038
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqN,
  input  logic       instrBoundary,
  input  logic       eiExec,
  input  logic       diExec,
  input  logic       fetchReady,
  output logic       injectValid,
  output logic [7:0] injectOpcode,
  output logic       holdPc,
  output logic       ieFlag
);

  localparam logic [2:0] VEC_SLOT   = VECTOR_ADDR[5:3];
  localparam logic [7:0] RST_OPCODE = restartOpcode(VEC_SLOT);

  ctlStrobes_t strobes;
  logic        maskActive;
  logic        pending;

  irq_accept_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .irqN          (irqN),
    .instrBoundary (instrBoundary),
    .eiExec        (eiExec),
    .diExec        (diExec),
    .ieFlag        (ieFlag),
    .maskActive    (maskActive),
    .pending       (pending),
    .strobes       (strobes)
  );

  irq_accept_datapath #(.RST_OPCODE(RST_OPCODE)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .fetchReady   (fetchReady),
    .ieFlag       (ieFlag),
    .maskActive   (maskActive),
    .pending      (pending),
    .injectValid  (injectValid),
    .injectOpcode (injectOpcode),
    .holdPc       (holdPc)
  );

  // R7
  disable_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    diExec |=> !ieFlag);

  // R9
  enable_loses_to_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eiExec && instrBoundary && !irqN && ieFlag && !holdPc && !maskActive) |=> !ieFlag && holdPc);

endmodule

// File: tb/tb_irq_accept_unit.sv
module tb_irq_accept_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] EXP_OP = {2'b11, 3'(16'h0038 >> 3), 3'b111};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqN = 1'b1, instrBoundary = 1'b0, eiExec = 1'b0, diExec = 1'b0, fetchReady = 1'b0;
  logic injectValid, holdPc, ieFlag;
  logic [7:0] injectOpcode;

  int checks = 0;
  int failures = 0;

  // reference state, derived from the requirements
  logic mIe = 1'b0, mMask = 1'b0, mPend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_unit dut (
    .clk(clk), .rstN(rstN), .irqN(irqN), .instrBoundary(instrBoundary),
    .eiExec(eiExec), .diExec(diExec), .fetchReady(fetchReady),
    .injectValid(injectValid), .injectOpcode(injectOpcode),
    .holdPc(holdPc), .ieFlag(ieFlag)
  );

  task automatic compare(input string tag);
    logic expInj;
    logic [7:0] expOp;
    expInj = mPend && fetchReady;
    expOp  = expInj ? EXP_OP : 8'h00;
    checks++;
    if (ieFlag !== mIe || holdPc !== mPend || injectValid !== expInj || injectOpcode !== expOp) begin
      failures++;
      $display("FAIL %s: got ie=%b hold=%b inj=%b op=%h expected ie=%b hold=%b inj=%b op=%h",
               tag, ieFlag, holdPc, injectValid, injectOpcode, mIe, mPend, expInj, expOp);
    end
  endtask

  // drive at negedge, check before the edge, advance model at the edge
  task automatic step(input logic i, input logic b, input logic e, input logic d,
                      input logic f, input string tag);
    logic acc;
    irqN = i; instrBoundary = b; eiExec = e; diExec = d; fetchReady = f;
    #1;
    compare(tag);
    acc = b && !i && mIe && !mMask && !mPend;
    @(posedge clk);
    if (acc || d) mIe = 1'b0;
    else if (e)   mIe = 1'b1;
    if (e && !(acc || d)) mMask = 1'b1;
    else if (b || acc || d) mMask = 1'b0;
    if (acc) mPend = 1'b1;
    else if (mPend && f) mPend = 1'b0;
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    irqN = 1'b1; instrBoundary = 1'b0; eiExec = 1'b0; diExec = 1'b0; fetchReady = 1'b0;
    mIe = 1'b0; mMask = 1'b0; mPend = 1'b0;
    #(CLK_PERIOD*2);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    doReset();
    step(1,0,0,0,0,"R1 reset state");

    // R2: disabled request ignored
    step(0,1,0,0,1,"R2 disabled boundary");
    step(1,0,0,0,1,"R2 no hold after disabled request");

    // R6: enable, then first boundary masked
    step(1,0,1,0,0,"R6 enable strobe");
    step(0,1,0,0,1,"R6 masked boundary");
    step(0,0,0,0,1,"R6 nothing taken");
    // R2 / R5: second boundary accepted, fetch delayed
    step(0,1,0,0,0,"R2 accept");
    step(1,0,0,0,0,"R5 flag cleared, R3 hold without fetch");
    step(1,0,0,0,0,"R3 still holding");
    step(1,0,0,0,1,"R4 injected opcode");
    step(1,0,0,0,1,"R3 single pulse");

    // R8: level held, re-enabled
    step(0,1,0,0,1,"R8 held line while disabled");
    step(0,0,1,0,1,"R8 enable");
    step(0,1,0,0,1,"R8 masked");
    step(0,1,0,0,1,"R8 re-accept");
    step(0,0,0,0,1,"R8 inject");
    step(0,0,0,0,1,"R8 done");
    // R8: low between boundaries not remembered
    step(1,0,1,0,0,"R8 enable");
    step(1,1,0,0,0,"R8 mask consumed");
    step(0,0,0,0,0,"R8 low off-boundary");
    step(1,1,0,0,1,"R8 boundary with line high");
    step(1,0,0,0,1,"R8 nothing pending");

    // R7: disable immediate, and wins over enable
    step(1,0,0,1,0,"R7 disable");
    step(1,0,0,0,0,"R7 flag low");
    step(1,0,1,1,0,"R7 both strobes");
    step(0,1,0,0,0,"R7 flag low after both");
    step(1,0,0,0,0,"R7 no take");

    // R9: enable with accepted boundary
    step(1,0,1,0,0,"R9 enable");
    step(1,1,0,0,0,"R9 mask consumed");
    step(0,1,1,0,0,"R9 accept with enable");
    step(1,0,0,0,0,"R9 flag cleared");
    step(1,0,0,0,1,"R9 inject");

    // R10: reset drops pending
    step(1,0,1,0,0,"R10 enable");
    step(1,1,0,0,0,"R10 mask consumed");
    step(0,1,0,0,0,"R10 accept");
    doReset();
    step(1,0,0,0,1,"R10 pending dropped");

    // sweep over all input combinations from reachable states
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[7], lfsr[1], lfsr[2] & lfsr[5], lfsr[3] & lfsr[6] & lfsr[9],
           lfsr[4], "R2 sweep");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule